// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This master-side block puts a two-wire serial bus back into a known state after a transfer was cut short, power dropped, or a reset landed in the middle of a transaction. A slave left half-way through a byte may still be driving the data line low. A one-cycle request starts a fixed pattern. First comes a start condition, if the data line allows one. Then nine dummy clocks follow with data released. The pattern closes with a start condition and a stop condition directly after it.

Both lines are driven through open-drain enables: a high enable pulls the line low, and a low enable releases it. Timing comes from a quarter-period tick whose divisor is a runtime input. One clock period takes four quarters, two low and two high. One quarter after the closing stop, the block samples the data line and raises a one-cycle done pulse. A fail flag goes with that pulse when the data line is still low, so that software can fall back to a power cycle. Ordinary byte transfers are not part of this block.

Top module: `bus_recover`

## Requirements
- R1: After reset both open-drain enables are 0 (lines released) and busy_o, done_o and fail_o are 0.
- R2: A request accepted while the data line reads high begins with a start condition: SDA falls while SCL is high, before the first SCL low phase.
- R3: A request accepted while the data line reads low skips the initial start; SCL goes low on the first quarter and no start occurs before the clocks.
- R4: Every sequence produces exactly nine SCL rising edges, with the block releasing SDA during each SCL high phase.
- R5: The block changes its SDA enable while SCL is released only for the initial start, the closing start and the closing stop; all other SDA changes occur while SCL is low.
- R6: The sequence ends with a start (SDA falls, SCL high) followed by a stop (SDA rises, SCL high), with no SCL low phase between them.
- R7: Each quarter lasts qdiv_i+1 clock cycles. done_o rises exactly 41 quarters after the accepting edge when the initial start is issued, and 39 quarters after it when the start is skipped.
- R8: done_o is high for exactly one cycle. fail_o is 1 when SDA reads low one quarter after the stop, is valid together with done_o, holds until the next accepted request, and clears on acceptance.
- R9: A request while a sequence runs is ignored: the running sequence keeps its timing, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Recovery request pulse |
| qdiv_i | input | DIV_W | Quarter period minus one, in clock cycles |
| sda_i | input | 1 | Level read back from the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Data line still low after recovery |

## Verification
The request is taken at one clock edge. The line enables follow it on the next cycle, with the state registers and no extra stage. The bench counts clock edges from the accepting edge and samples every output at the falling clock edge. It expects done_o and fail_o after edge 41·(qdiv_i+1) when the start is issued and after edge 39·(qdiv_i+1) when it is skipped. It also counts start, stop and rising-clock events on the resolved lines within that same window. For the ignored request, the bench checks that done_o rises at the unchanged edge count and that busy_o stays low over the following idle window.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CLK,
    ST_RSTART,
    ST_STOP
  } rec_state_e;

  // quarter counts per phase
  localparam int unsigned START_Q  = 2;
  localparam int unsigned CLK_Q    = 4;
  localparam int unsigned RSTART_Q = 2;
  localparam int unsigned STOP_Q   = 1;
  localparam int unsigned QC_W     = 2;
endpackage

// File: rtl/bus_recover_tick.sv
module bus_recover_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (en_i)     cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  p_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import bus_recover_pkg::*;
#(
  parameter int unsigned NUM_CLKS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tick_i,
  input  logic sda_i,
  output logic clr_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned BIT_W = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NUM_CLKS - 1);

  rec_state_e       st_q;
  logic [QC_W-1:0]  qc_q;
  logic [BIT_W-1:0] bit_q;
  logic             hold_q;
  logic             done_q, fail_q;

  assign busy_o = (st_q != ST_IDLE);
  assign clr_o  = (st_q == ST_IDLE) && req_i;
  assign done_o = done_q;
  assign fail_o = fail_q;

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (st_q)
      ST_START, ST_RSTART: sda_oe_o = 1'b1;
      ST_CLK: begin
        scl_oe_o = (qc_q < QC_W'(CLK_Q / 2));
        sda_oe_o = (qc_q == '0) && hold_q;  // keep start low until SCL is down
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      qc_q   <= '0;
      bit_q  <= '0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          fail_q <= 1'b0;
          qc_q   <= '0;
          bit_q  <= '0;
          hold_q <= sda_i;
          st_q   <= sda_i ? ST_START : ST_CLK;
        end
        ST_START: if (tick_i) begin
          if (qc_q == QC_W'(START_Q - 1)) begin
            qc_q <= '0;
            st_q <= ST_CLK;
          end else qc_q <= qc_q + 1'b1;
        end
        ST_CLK: if (tick_i) begin
          if (qc_q == '0) hold_q <= 1'b0;
          if (qc_q == QC_W'(CLK_Q - 1)) begin
            qc_q <= '0;
            if (bit_q == LAST_BIT) st_q <= ST_RSTART;
            else                   bit_q <= bit_q + 1'b1;
          end else qc_q <= qc_q + 1'b1;
        end
        ST_RSTART: if (tick_i) begin
          if (qc_q == QC_W'(RSTART_Q - 1)) begin
            qc_q <= '0;
            st_q <= ST_STOP;
          end else qc_q <= qc_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (qc_q == QC_W'(STOP_Q - 1)) begin
            qc_q   <= '0;
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            fail_q <= !sda_i;
          end else qc_q <= qc_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_sda_moves_scl_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && !$stable(sda_oe_o))
      |-> (st_q inside {ST_START, ST_RSTART, ST_STOP}));

  p_step_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !tick_i) |=> $stable(st_q));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fail_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  p_req_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && st_q != ST_STOP && req_i) |=> (st_q != ST_IDLE));

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: rtl/bus_recover.sv
module bus_recover #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned NUM_CLKS = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DIV_W-1:0] qdiv_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);
  logic tick, clr;

  bus_recover_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (busy_o),
    .div_i  (qdiv_i),
    .tick_o (tick)
  );

  bus_recover_seq #(.NUM_CLKS(NUM_CLKS)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .tick_i   (tick),
    .sda_i    (sda_i),
    .clr_o    (clr),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
  );
endmodule

// File: tb/test_bus_recover.sv
module test_bus_recover;
  localparam int unsigned DIV_W = 16;

  typedef struct packed {
    logic [7:0] qdiv;
    logic [1:0] mode;    // 0 free, 1 held then released, 2 stuck low
    logic [7:0] quarters;
    logic       fail;
    logic [1:0] starts;
    logic [1:0] stops;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{8'd0, 2'd0, 8'd41, 1'b0, 2'd2, 2'd1},
    '{8'd3, 2'd0, 8'd41, 1'b0, 2'd2, 2'd1},
    '{8'd1, 2'd1, 8'd39, 1'b0, 2'd1, 2'd1},
    '{8'd2, 2'd2, 8'd39, 1'b1, 2'd0, 2'd0},
    '{8'd4, 2'd0, 8'd41, 1'b0, 2'd2, 2'd1},
    '{8'd0, 2'd2, 8'd39, 1'b1, 2'd0, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [DIV_W-1:0] qdiv = '0;
  logic slave_hold = 1'b0;
  logic scl_oe, sda_oe, busy, done, fail;
  logic scl_l, sda_l;
  int total = 0, bad = 0;
  bit finished = 0;

  assign scl_l = !scl_oe;
  assign sda_l = !(sda_oe || slave_hold);

  always #5 clk = !clk;

  bus_recover #(.DIV_W(DIV_W)) i_bus_recover (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .qdiv_i(qdiv), .sda_i(sda_l),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int q, input int mode, input int exp_quarters,
                         input int exp_fail, input int exp_starts, input int exp_stops,
                         input bit extra_req);
    int rises = 0, falls = 0, starts = 0, stops = 0, done_cnt = 0, done_k = -1;
    int last_start = -1, stop_k = -1, fail_at_done = -1;
    bit fall_after_start = 0;
    bit first_low = 0;
    logic pscl, psda;
    int lim = exp_quarters * (q + 1) + 30;
    qdiv = DIV_W'(q);
    slave_hold = (mode != 0);
    @(negedge clk);
    pscl = scl_l; psda = sda_l;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (k == 1) first_low = !scl_l;
      if (extra_req && k == 20) req = 1'b1;
      if (extra_req && k == 21) req = 1'b0;
      if (!pscl && scl_l) rises++;
      if (pscl && !scl_l) begin
        falls++;
        fall_after_start = 1;
        if (mode == 1 && falls == 3) slave_hold = 1'b0;
      end
      if (pscl && scl_l && psda && !sda_l) begin
        starts++; last_start = k; fall_after_start = 0;
      end
      if (pscl && scl_l && !psda && sda_l) begin
        stops++; stop_k = k;
        chk("R6 no SCL low between closing start and stop", fall_after_start, 0);
      end
      if (done) begin
        done_cnt++;
        if (done_k < 0) begin done_k = k; fail_at_done = fail; end
      end
      if (extra_req && k > exp_quarters * (q + 1)) chk("R9 no second sequence", busy, 0);
      pscl = scl_l; psda = sda_l;
    end
    chk("R7 done edge count", done_k, exp_quarters * (q + 1));
    chk("R8 done width", done_cnt, 1);
    chk("R8 fail value", fail_at_done, exp_fail);
    chk("R8 fail held", fail, exp_fail);
    chk("R4 nine SCL rises", rises, 9);
    chk("R2/R3 start count", starts, exp_starts);
    chk("R6 stop count", stops, exp_stops);
    if (mode != 0) chk("R3 SCL low on first quarter", first_low, 1);
    if (exp_stops == 1) chk("R6 start precedes stop", (last_start > 0 && last_start < stop_k) ? 1 : 0, 1);
    slave_hold = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done/fail", {done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_seq(int'(VEC[v].qdiv), int'(VEC[v].mode), int'(VEC[v].quarters),
              int'(VEC[v].fail), int'(VEC[v].starts), int'(VEC[v].stops), 1'b0);

    // R8: fail holds through idle, clears on next acceptance
    repeat (10) @(negedge clk);
    chk("R8 fail held while idle", fail, 1);
    qdiv = DIV_W'(1);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R8 fail cleared on accept", fail, 0);
    chk("R2 start drives SDA low first", {scl_oe, sda_oe}, 2'b01);
    wait (!busy);
    repeat (3) @(negedge clk);

    // R9: extra request mid-sequence is dropped
    run_seq(1, 0, 41, 0, 2, 1, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule